// File: doc/BRIEF.md
# Selectable Generator Stream Burst Multiplexer

This block gathers the word streams of several pseudorandom generator cores, each an AXI4-Stream source, and passes exactly one of them to a single AXI4-Stream master port that feeds the stream-to-memory receive channel of a DMA engine. Two CPU-written inputs choose the generator and the number of words in each burst. The block cuts the selected stream into bursts and marks the final word of every burst with TLAST, so each burst becomes one DMA receive transfer.

An enable input starts bursting. Generator choice and burst length are latched only when a burst begins, so a CPU write never splits or reroutes a burst that is already under way. When enable drops, the open burst still runs to its TLAST beat and the block then goes quiet. Generators that are not selected see TREADY low and hold their words until they are chosen again.

Top module: `prng_burst_mux`

## Requirements
- R1: While bursting, m_tdata_o equals the tdata of the generator latched for the current burst; no other generator's word reaches the output.
- R2: src_tready_o is zero for every generator except the latched one, whose bit equals m_tready_i while bursting; at most one bit is set.
- R3: While bursting, m_tvalid_o equals the tvalid of the latched generator.
- R4: m_tlast_o is high exactly on the N-th accepted beat of a burst of length N (beats counted as m_tvalid_o and m_tready_i both high at a clock edge), and the next burst counts from one again.
- R5: A burst length input of 0 produces one-beat bursts (m_tlast_o on every beat).
- R6: sel_i and burst_len_i are sampled only at the edge that starts bursting from idle and at the edge that accepts a TLAST beat; changes at any other time have no effect on the open burst.
- R7: With enable_i high at an idle clock edge, bursting starts on the next cycle; with enable_i low at the TLAST beat, the block goes idle, driving m_tvalid_o and all of src_tready_o low.
- R8: After reset the block is idle: m_tvalid_o, m_tlast_o and src_tready_o are all zero.
- R9: While m_tvalid_o is high and m_tready_i is low, m_tvalid_o, m_tdata_o and m_tlast_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Burst enable from CPU register |
| sel_i | input | SEL_W | Generator index from CPU register |
| burst_len_i | input | LEN_W | Beats per burst, 0 taken as 1 |
| src_tdata_i | input | N_SRC*DATA_W | Packed generator words, source i at bits [i*DATA_W +: DATA_W] |
| src_tvalid_i | input | N_SRC | Generator valid flags |
| src_tready_o | output | N_SRC | Generator ready flags |
| m_tdata_o | output | DATA_W | Output stream data |
| m_tvalid_o | output | 1 | Output stream valid |
| m_tready_i | input | 1 | Output stream ready from DMA |
| m_tlast_o | output | 1 | Last beat of burst |

## Verification
A wrong latched generator index shows at the very next accepted beat as a word carrying another source's tag or an out-of-order sequence number, and as a ready pulse to the wrong source. A beat counter that slips shows at the end of the current burst as TLAST one or more beats early or late, which the bench sees against its own beat count. Config leaking in mid-burst appears within a cycle of the CPU write as a source or length change before the TLAST beat; a lost enable drain appears as the valid line dropping before TLAST.

// File: rtl/prng_mux_pkg.sv
package prng_mux_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BURST = 1'b1} burst_st_e;
endpackage

// File: rtl/prng_burst_ctrl.sv
module prng_burst_ctrl
  import prng_mux_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int LEN_W = 8,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_i,
  output logic             active_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             last_o
);
  burst_st_e        st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [LEN_W-1:0] last_idx_q, last_idx_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             at_last, load;

  assign at_last = (cnt_q == last_idx_q);
  // config is sampled only at a boundary
  assign load = (st_q == ST_IDLE) || (beat_i && at_last);

  always_comb begin
    st_d       = st_q;
    sel_d      = sel_q;
    last_idx_d = last_idx_q;
    cnt_d      = cnt_q;
    if (load) begin
      cnt_d = '0;
      if (enable_i) begin
        st_d       = ST_BURST;
        sel_d      = sel_i;
        last_idx_d = (len_i == '0) ? '0 : len_i - 1'b1;
      end else begin
        st_d = ST_IDLE;
      end
    end else if (beat_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sel_q      <= '0;
      last_idx_q <= '0;
      cnt_q      <= '0;
    end else begin
      st_q       <= st_d;
      sel_q      <= sel_d;
      last_idx_q <= last_idx_d;
      cnt_q      <= cnt_d;
    end
  end

  assign active_o = (st_q == ST_BURST);
  assign sel_o    = sel_q;
  assign last_o   = active_o && at_last;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_idx_q);
  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !(beat_i && at_last)) |=> ($stable(sel_q) && $stable(last_idx_q)));
  p_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !(beat_i && at_last)) |=> active_o);
endmodule

// File: rtl/prng_src_sel.sv
module prng_src_sel #(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 64,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    active_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [N_SRC*DATA_W-1:0] src_tdata_i,
  input  logic [N_SRC-1:0]        src_tvalid_i,
  output logic [N_SRC-1:0]        src_tready_o,
  output logic [DATA_W-1:0]       m_tdata_o,
  output logic                    m_tvalid_o,
  input  logic                    m_tready_i
);
  logic [DATA_W-1:0] words [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign words[i]        = src_tdata_i[i*DATA_W +: DATA_W];
    assign src_tready_o[i] = active_i && m_tready_i && (sel_i == SEL_W'(i));
  end

  always_comb begin
    m_tdata_o  = '0;
    m_tvalid_o = 1'b0;
    if (int'(sel_i) < N_SRC) begin
      m_tdata_o  = words[sel_i];
      m_tvalid_o = active_i && src_tvalid_i[sel_i];
    end
  end

  always_comb begin
    a_one_ready_r2: assert ($onehot0(src_tready_o));
  end
endmodule

// File: rtl/prng_burst_mux.sv
module prng_burst_mux #(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [LEN_W-1:0]        burst_len_i,
  input  logic [N_SRC*DATA_W-1:0] src_tdata_i,
  input  logic [N_SRC-1:0]        src_tvalid_i,
  output logic [N_SRC-1:0]        src_tready_o,
  output logic [DATA_W-1:0]       m_tdata_o,
  output logic                    m_tvalid_o,
  input  logic                    m_tready_i,
  output logic                    m_tlast_o
);
  logic             active;
  logic [SEL_W-1:0] sel_q;
  logic             last;
  logic             beat;

  assign beat      = m_tvalid_o && m_tready_i;
  assign m_tlast_o = last;

  prng_burst_ctrl #(.N_SRC(N_SRC), .LEN_W(LEN_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .sel_i    (sel_i),
    .len_i    (burst_len_i),
    .beat_i   (beat),
    .active_o (active),
    .sel_o    (sel_q),
    .last_o   (last)
  );

  prng_src_sel #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_sel (
    .active_i     (active),
    .sel_i        (sel_q),
    .src_tdata_i  (src_tdata_i),
    .src_tvalid_i (src_tvalid_i),
    .src_tready_o (src_tready_o),
    .m_tdata_o    (m_tdata_o),
    .m_tvalid_o   (m_tvalid_o),
    .m_tready_i   (m_tready_i)
  );

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!m_tvalid_o && !m_tlast_o && (src_tready_o == '0)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));
  p_ready_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && m_tready_i) |-> ($countones(src_tready_o) == 1));
endmodule

// File: tb/prng_burst_mux_test.sv
`timescale 1ns/1ps
module prng_burst_mux_test;
  localparam int N_SRC  = 4;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 8;
  localparam int SEL_W  = 2;
  localparam int RUN    = 8000;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    enable_i = 1'b0;
  logic [SEL_W-1:0]        sel_i = '0;
  logic [LEN_W-1:0]        burst_len_i = '0;
  logic [N_SRC*DATA_W-1:0] src_tdata_i;
  logic [N_SRC-1:0]        src_tvalid_i = '0;
  logic [N_SRC-1:0]        src_tready_o;
  logic [DATA_W-1:0]       m_tdata_o;
  logic                    m_tvalid_o;
  logic                    m_tready_i = 1'b0;
  logic                    m_tlast_o;

  prng_burst_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  logic [55:0] seq [N_SRC];
  logic [15:0] lfsr = 16'hACE1;

  for (genvar i = 0; i < N_SRC; i++) begin : g_data
    assign src_tdata_i[i*DATA_W +: DATA_W] = {8'(i), seq[i]};
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // bench model
  bit          b_act = 0;
  int          cur_sel = 0;
  int          cur_len = 1;
  int          beat = 0;
  bit          pend = 0;
  int          pend_src = 0;
  int          fires = 0;
  int          bursts = 0;
  int          short_bursts = 0;

  initial begin
    for (int i = 0; i < N_SRC; i++) seq[i] = '0;
    #20;
    chk(m_tvalid_o == 1'b0, "R8 tvalid in reset", 64'(m_tvalid_o), 64'd0);
    chk(src_tready_o == '0, "R8 tready in reset", 64'(src_tready_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(m_tvalid_o == 1'b0 && m_tlast_o == 1'b0, "R8 idle after reset", 64'({m_tvalid_o, m_tlast_o}), 64'd0);
    for (int cyc = 0; cyc < RUN; cyc++) begin
      @(negedge clk_i);
      // apply handshake of the edge just passed
      if (pend) begin
        seq[pend_src] = seq[pend_src] + 1'b1;
        src_tvalid_i[pend_src] = 1'b0;
        pend = 0;
      end
      step_lfsr();
      for (int i = 0; i < N_SRC; i++)
        if (!src_tvalid_i[i]) src_tvalid_i[i] = (lfsr[i] | lfsr[i+4]);
      m_tready_i = (lfsr[8] | lfsr[9]);
      if ((cyc % 7) == 0) begin
        int k;
        k = cyc / 7;
        sel_i       = SEL_W'(k % N_SRC);
        burst_len_i = LEN_W'((k / N_SRC) % 6);
      end
      enable_i = ((cyc % 600) < 540) && (cyc < RUN - 200);
      #1;
      if (b_act) begin
        bit fire;
        bit lst;
        lst  = (beat == cur_len - 1);
        fire = src_tvalid_i[cur_sel] && m_tready_i;
        chk(m_tvalid_o == src_tvalid_i[cur_sel], "R3 tvalid follows source", 64'(m_tvalid_o), 64'(src_tvalid_i[cur_sel]));
        chk(src_tready_o == (N_SRC'(m_tready_i) << cur_sel), "R2 ready routing", 64'(src_tready_o), 64'(N_SRC'(m_tready_i) << cur_sel));
        chk(m_tlast_o == lst, (cur_len == 1) ? "R5 tlast one beat" : "R4 tlast position", 64'(m_tlast_o), 64'(lst));
        if (m_tvalid_o)
          chk(m_tdata_o == {8'(cur_sel), seq[cur_sel]}, "R1 R6 data source and order", m_tdata_o, {8'(cur_sel), seq[cur_sel]});
        if (m_tvalid_o && !m_tready_i) begin
          logic [63:0] held;
          held = m_tdata_o;
          @(posedge clk_i); #1;
          chk(m_tvalid_o && m_tdata_o == held, "R9 hold under stall", m_tdata_o, held);
        end else if (fire) begin
          fires++;
          pend = 1; pend_src = cur_sel;
          if (lst) begin
            bursts++;
            if (cur_len == 1) short_bursts++;
            beat = 0;
            if (enable_i) begin
              cur_sel = int'(sel_i);
              cur_len = (burst_len_i == 0) ? 1 : int'(burst_len_i);
            end else begin
              b_act = 0;
            end
          end else begin
            beat++;
          end
        end
      end else begin
        chk(m_tvalid_o == 1'b0 && src_tready_o == '0, "R7 idle quiet", 64'({src_tready_o, m_tvalid_o}), 64'd0);
        if (enable_i) begin
          b_act = 1;
          beat = 0;
          cur_sel = int'(sel_i);
          cur_len = (burst_len_i == 0) ? 1 : int'(burst_len_i);
        end
      end
    end
    chk(fires > 1000, "R1 R7 traffic progress", 64'(fires), 64'd1000);
    chk(short_bursts > 10, "R5 zero length bursts seen", 64'(short_bursts), 64'd10);
    chk(!b_act && m_tvalid_o == 1'b0, "R7 idle after final drain", 64'(m_tvalid_o), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule